// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small 8-bit processor built around one accumulator and a 32-word by 8-bit memory that lives inside the core. Each instruction is one memory word. Its top three bits select the operation and its low five bits name an operand address. A control state machine steps through every instruction in a fixed series of single-cycle states. It first fetches the word through the memory address register, then decodes it, then runs one of three execute paths: load the accumulator, add a memory operand into the accumulator, or write the accumulator back to memory.

Every memory access goes through the memory address register. That register is fed by a two-way mux that picks either the program counter or the operand address held in the instruction register. Read data is first captured in an input data register. Store data is staged in an output data register.

A preload port writes words straight into memory. It is meant to be used while the core is held in reset. Debug outputs show the program counter, address register, instruction register, both data registers, the accumulator and the program-counter step strobe.

Controller states and transitions:
- The fetch chain runs FETCH_MAR → FETCH_RD → FETCH_MDR → FETCH_IR → DECODE.
- DECODE goes to LD_MAR for opcode 000, to AD_MAR for 001 and to ST_MAR for 010. Any other opcode returns to FETCH_MAR.
- The load path runs LD_MAR → LD_RD → LD_MDR → LD_ACC → FETCH_MAR.
- The add path runs AD_MAR → AD_RD → AD_MDR → AD_ACC → FETCH_MAR.
- The store path runs ST_MAR → ST_MDR → ST_WR → FETCH_MAR.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, address register, instruction register, both data registers and the accumulator, and puts the controller in FETCH_MAR, where the step strobe is high.
- R2: Fetch loads the instruction register with the memory word at the program counter's address. Bits [7:5] of that word are the opcode and bits [4:0] are the operand address.
- R3: The program counter steps by exactly one per instruction, only in FETCH_MAR, and wraps from 31 to 0.
- R4: Opcode 000 (load) sets the accumulator to the memory word at the operand address. The instruction takes 9 cycles.
- R5: Opcode 001 (add) sets the accumulator to the accumulator plus the memory operand, modulo 256. The instruction takes 9 cycles.
- R6: Opcode 010 (store) writes the accumulator to memory at the operand address and copies it into the output data register. The accumulator is unchanged and the instruction takes 8 cycles.
- R7: Opcodes 011 to 111 change nothing but the fetch state and take 5 cycles.
- R8: After a load, add or store, the address register holds the operand address. After any other opcode it holds the address the instruction was fetched from.
- R9: While the preload strobe is high, the preload data is written to the preload address, taking priority over the core's own memory port. The words persist across reset.
- R10: Memory is written by the core only in ST_WR, and at that point the address register equals the operand address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init_we | input | 1 | Preload write strobe |
| init_addr | input | 5 | Preload word address |
| init_data | input | 8 | Preload word |
| dbg_pc | output | 5 | Program counter |
| dbg_mar | output | 5 | Memory address register |
| dbg_ir | output | 8 | Instruction register |
| dbg_mdr_in | output | 8 | Input data register |
| dbg_mdr_out | output | 8 | Output data register |
| dbg_acc | output | 8 | Accumulator |
| dbg_pc_step | output | 1 | Program-counter step strobe |

## Verification
The program mixes loads, adds (one of them carries past 255), stores and two unused opcodes, so each execute path is told apart by its cycle count, its effect on the accumulator and the address register it leaves behind. A load from a location written earlier by a store shows that the write reached memory. A later add that uses a stored word as its operand shows the same thing for the add path.

A program made only of unused opcodes runs the counter through its wrap and shows that the accumulator is untouched. A one-word program preloaded after a mid-run reset shows that the preload port and reset clear registers but not memory.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        S_FETCH_MAR, S_FETCH_RD, S_FETCH_MDR, S_FETCH_IR, S_DECODE,
        S_LD_MAR, S_LD_RD, S_LD_MDR, S_LD_ACC,
        S_AD_MAR, S_AD_RD, S_AD_MDR, S_AD_ACC,
        S_ST_MAR, S_ST_MDR, S_ST_WR
    } state_t;

    typedef enum logic [2:0] {
        ALU_ADD    = 3'd0,
        ALU_SUB    = 3'd1,
        ALU_AND    = 3'd2,
        ALU_OR     = 3'd3,
        ALU_PASS_B = 3'd4,
        ALU_PASS_A = 3'd5
    } alu_op_t;

    localparam logic [2:0] OP_LOAD  = 3'd0;
    localparam logic [2:0] OP_ADD   = 3'd1;
    localparam logic [2:0] OP_STORE = 3'd2;

    typedef struct packed {
        logic    pc_inc;
        logic    mar_ld;
        logic    mar_sel;
        logic    mdri_ld;
        logic    ir_ld;
        logic    mdro_ld;
        logic    acc_ld;
        logic    mem_we;
        alu_op_t alu_op;
    } ctrl_t;

endpackage

// File: rtl/acc_reg.sv
module acc_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[addr] <= wdata;
        else    rdata <= store_q[addr];
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_AND:    y = a & b;
            ALU_OR:     y = a | b;
            ALU_PASS_B: y = b;
            ALU_PASS_A: y = a;
            default:    y = a;
        endcase
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctl
);
    state_t state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH_MAR;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        unique case (state)
            S_FETCH_MAR: state_nx = S_FETCH_RD;
            S_FETCH_RD:  state_nx = S_FETCH_MDR;
            S_FETCH_MDR: state_nx = S_FETCH_IR;
            S_FETCH_IR:  state_nx = S_DECODE;
            S_DECODE: begin
                if      (opcode == OP_LOAD)  state_nx = S_LD_MAR;
                else if (opcode == OP_ADD)   state_nx = S_AD_MAR;
                else if (opcode == OP_STORE) state_nx = S_ST_MAR;
                else                         state_nx = S_FETCH_MAR;
            end
            S_LD_MAR:    state_nx = S_LD_RD;
            S_LD_RD:     state_nx = S_LD_MDR;
            S_LD_MDR:    state_nx = S_LD_ACC;
            S_LD_ACC:    state_nx = S_FETCH_MAR;
            S_AD_MAR:    state_nx = S_AD_RD;
            S_AD_RD:     state_nx = S_AD_MDR;
            S_AD_MDR:    state_nx = S_AD_ACC;
            S_AD_ACC:    state_nx = S_FETCH_MAR;
            S_ST_MAR:    state_nx = S_ST_MDR;
            S_ST_MDR:    state_nx = S_ST_WR;
            S_ST_WR:     state_nx = S_FETCH_MAR;
            default:     state_nx = S_FETCH_MAR;
        endcase
    end

    // Outputs per state
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_PASS_A;
        unique case (state)
            S_FETCH_MAR: begin
                ctl.mar_ld = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            S_FETCH_MDR: ctl.mdri_ld = 1'b1;
            S_FETCH_IR:  ctl.ir_ld   = 1'b1;
            S_LD_MAR, S_AD_MAR, S_ST_MAR: begin
                ctl.mar_ld  = 1'b1;
                ctl.mar_sel = 1'b1;
            end
            S_LD_MDR, S_AD_MDR: ctl.mdri_ld = 1'b1;
            S_LD_ACC: begin
                ctl.alu_op = ALU_PASS_B;
                ctl.acc_ld = 1'b1;
            end
            S_AD_ACC: begin
                ctl.alu_op = ALU_ADD;
                ctl.acc_ld = 1'b1;
            end
            S_ST_MDR: ctl.mdro_ld = 1'b1;
            S_ST_WR:  ctl.mem_we  = 1'b1;
            default: ;
        endcase
    end

    assert_fetch_chain_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH_IR) |=> (state == S_DECODE));

    assert_unused_op_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && opcode != OP_LOAD && opcode != OP_ADD && opcode != OP_STORE)
        |=> (state == S_FETCH_MAR));

    assert_store_tail_R6: assert property (@(posedge clk) disable iff (rst)
        (state == S_ST_MDR) |=> (state == S_ST_WR));
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [DATA_W-1:0] init_data,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [ADDR_W-1:0] dbg_mar,
    output logic [DATA_W-1:0] dbg_ir,
    output logic [DATA_W-1:0] dbg_mdr_in,
    output logic [DATA_W-1:0] dbg_mdr_out,
    output logic [DATA_W-1:0] dbg_acc,
    output logic              dbg_pc_step
);
    localparam int OP_W = DATA_W - ADDR_W;

    ctrl_t             ctl;
    logic [ADDR_W-1:0] pc, mar, mar_d, mem_addr;
    logic [DATA_W-1:0] ir, mdri, mdro, acc, alu_y, mem_q, mem_wd;
    logic              mem_we;

    acc_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk(clk), .rst(rst), .opcode(ir[DATA_W-1:ADDR_W]), .ctl(ctl)
    );

    // Program counter
    always_ff @(posedge clk) begin
        if (rst)             pc <= '0;
        else if (ctl.pc_inc) pc <= pc + 1'b1;
    end

    assign mar_d = ctl.mar_sel ? ir[ADDR_W-1:0] : pc;

    acc_reg #(.W(ADDR_W)) u_mar  (.clk(clk), .rst(rst), .ld(ctl.mar_ld),  .d(mar_d), .q(mar));
    acc_reg #(.W(DATA_W)) u_mdri (.clk(clk), .rst(rst), .ld(ctl.mdri_ld), .d(mem_q), .q(mdri));
    acc_reg #(.W(DATA_W)) u_ir   (.clk(clk), .rst(rst), .ld(ctl.ir_ld),   .d(mdri),  .q(ir));
    acc_reg #(.W(DATA_W)) u_mdro (.clk(clk), .rst(rst), .ld(ctl.mdro_ld), .d(acc),   .q(mdro));
    acc_reg #(.W(DATA_W)) u_acc  (.clk(clk), .rst(rst), .ld(ctl.acc_ld),  .d(alu_y), .q(acc));

    acc_alu #(.DATA_W(DATA_W)) u_alu (.op(ctl.alu_op), .a(acc), .b(mdri), .y(alu_y));

    // Preload port takes the memory port over from the core
    assign mem_we   = init_we | ctl.mem_we;
    assign mem_addr = init_we ? init_addr : mar;
    assign mem_wd   = init_we ? init_data : mdro;

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wd), .rdata(mem_q)
    );

    assign dbg_pc      = pc;
    assign dbg_mar     = mar;
    assign dbg_ir      = ir;
    assign dbg_mdr_in  = mdri;
    assign dbg_mdr_out = mdro;
    assign dbg_acc     = acc;
    assign dbg_pc_step = ctl.pc_inc;

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_inc |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl.pc_inc |=> $stable(pc));

    assert_acc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl.acc_ld |=> $stable(acc));

    assert_write_data_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_we |-> (mdro == acc));

    assert_write_addr_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_we |-> (mar == ir[ADDR_W-1:0]));
endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_we = 1'b0;
    logic [4:0] init_addr = '0;
    logic [7:0] init_data = '0;
    logic [4:0] dbg_pc, dbg_mar;
    logic [7:0] dbg_ir, dbg_mdr_in, dbg_mdr_out, dbg_acc;
    logic       dbg_pc_step;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst(rst), .init_we(init_we), .init_addr(init_addr),
        .init_data(init_data), .dbg_pc(dbg_pc), .dbg_mar(dbg_mar), .dbg_ir(dbg_ir),
        .dbg_mdr_in(dbg_mdr_in), .dbg_mdr_out(dbg_mdr_out), .dbg_acc(dbg_acc),
        .dbg_pc_step(dbg_pc_step)
    );

    // {cycles, instruction word, accumulator after, pc after}
    localparam logic [31:0] VEC [11] = '{
        32'h09_18_25_01,  // R4 load [24]
        32'h09_39_38_02,  // R5 add  [25]
        32'h09_3A_28_03,  // R5 add  [26], wraps past 255
        32'h08_5C_28_04,  // R6 store [28]
        32'h05_7F_28_05,  // R7 opcode 011
        32'h09_1D_7F_06,  // R4 load [29]
        32'h09_3C_A7_07,  // R5 add  [28] (stored word)
        32'h05_E0_A7_08,  // R7 opcode 111
        32'h09_1C_28_09,  // R6 load back [28]
        32'h08_58_28_0A,  // R6 store [24]
        32'h09_38_50_0B   // R5 add  [24] (stored word)
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic preload(input int a, input logic [7:0] d);
        @(negedge clk);
        init_we   = 1'b1;
        init_addr = 5'(a);
        init_data = d;
    endtask

    task automatic preload_done();
        @(negedge clk);
        init_we = 1'b0;
    endtask

    // Runs one instruction from a negedge in FETCH_MAR and counts step pulses
    task automatic run_instr(input int cyc, output int steps);
        steps = 0;
        for (int c = 0; c < cyc; c++) begin
            if (dbg_pc_step) steps++;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int steps;
        logic [7:0] mem_img [32];

        // Program and data image
        for (int a = 0; a < 32; a++) mem_img[a] = 8'h60;
        for (int k = 0; k < 11; k++) mem_img[k] = VEC[k][23:16];
        mem_img[24] = 8'h25; mem_img[25] = 8'h13; mem_img[26] = 8'hF0;
        mem_img[28] = 8'h00; mem_img[29] = 8'h7F;

        rst = 1'b1;
        for (int a = 0; a < 32; a++) preload(a, mem_img[a]);  // R9
        preload_done();

        // R1 reset state
        check("R1 pc",      {3'b0, dbg_pc}, 8'h00);
        check("R1 mar",     {3'b0, dbg_mar}, 8'h00);
        check("R1 ir",      dbg_ir, 8'h00);
        check("R1 mdr_in",  dbg_mdr_in, 8'h00);
        check("R1 mdr_out", dbg_mdr_out, 8'h00);
        check("R1 acc",     dbg_acc, 8'h00);
        check("R1 step",    {7'b0, dbg_pc_step}, 8'h01);

        rst = 1'b0;
        for (int k = 0; k < 11; k++) begin
            logic [7:0] ir_e;
            logic [4:0] mar_e;
            ir_e  = VEC[k][23:16];
            mar_e = (ir_e[7:5] <= 3'd2) ? ir_e[4:0] : 5'(k);
            run_instr(int'(VEC[k][31:24]), steps);
            check($sformatf("R2 ir #%0d", k), dbg_ir, ir_e);
            check($sformatf("R4/R5 acc #%0d", k), dbg_acc, VEC[k][15:8]);
            check($sformatf("R3 pc #%0d", k), {3'b0, dbg_pc}, VEC[k][7:0]);
            check($sformatf("R3 steps #%0d", k), 8'(steps), 8'd1);
            check($sformatf("R8 mar #%0d", k), {3'b0, dbg_mar}, {3'b0, mar_e});
            if (ir_e[7:5] == 3'd2)
                check($sformatf("R6 mdr_out #%0d", k), dbg_mdr_out, VEC[k][15:8]);
            check($sformatf("R7 fetch-state #%0d", k), {7'b0, dbg_pc_step}, 8'h01);
        end

        // R1 mid-run reset, R9 preload keeps memory but writes new word
        @(negedge clk);
        rst = 1'b1;
        preload(0, 8'h1F);
        preload(31, 8'hC3);
        preload_done();
        check("R1 acc after reset", dbg_acc, 8'h00);
        check("R1 ir after reset",  dbg_ir, 8'h00);
        rst = 1'b0;
        run_instr(9, steps);
        check("R9 preload load", dbg_acc, 8'hC3);
        run_instr(9, steps);  // word 1 is still ADD [25] from before reset
        check("R9 memory kept across reset", dbg_acc, 8'hD6);

        // R3 wrap and R7 no effect: all unused opcodes
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 32; a++) preload(a, 8'h60 | 8'(a % 2) << 7);
        preload_done();
        rst = 1'b0;
        for (int k = 0; k < 31; k++) run_instr(5, steps);
        check("R3 pc at 31", {3'b0, dbg_pc}, 8'd31);
        run_instr(5, steps);
        check("R3 pc wraps", {3'b0, dbg_pc}, 8'd0);
        check("R7 acc untouched", dbg_acc, 8'h00);
        check("R7 mdr_out untouched", dbg_mdr_out, 8'h00);
        check("R10 no write on unused", {3'b0, dbg_mar}, 8'd31);

        finish_run();
    end
endmodule